// File: doc/BRIEF.md
# Nibble-Symbol Correcting Memory ECC

This block protects a memory word using 4-bit symbols, so that one symbol lines up with one x4 DRAM device. On the write side it takes a data word, derives three check nibbles from it and returns a codeword that stores the data and its check nibbles together. On the read side it takes a stored codeword and computes three syndromes over GF(16). An error confined to any one nibble is repaired in place and flagged as corrected. That covers any pattern of one to four bits, up to a whole device returning garbage. An error spread over two nibbles is flagged as uncorrectable, and the data field is passed on untouched.

The code is a Reed-Solomon style code: 12 data nibbles and 3 check nibbles, 15 symbols in all. The code's roots are 1, a and a^2, where a is a root of x^4+x+1. Both ports are single-cycle pipelines with a valid strobe. The result appears on the clock edge after the input is accepted, so corrected data comes back with no retry.

Top module: `nibble_ecc`

## Requirements
- R1: While reset is asserted, and until the internal reset has been released, `wr_out_valid`, `rd_out_valid`, `rd_fixed` and `rd_bad` are 0.
- R2: One cycle after `wr_valid`, `wr_out_valid` is 1 and `wr_code` holds the codeword. Nibble i of the codeword is bits [4i+3:4i]. Nibbles 3..14 equal data nibbles 0..11 (`wr_code[59:12] == wr_data`). Nibbles 0..2 are chosen so that sum over i of c_i·a^(j·i) is 0 for j = 0, 1, 2. Arithmetic is in GF(16) modulo x^4+x+1, with a = 4'b0010.
- R3: Reading an unmodified codeword returns its data field, with `rd_fixed` = 0 and `rd_bad` = 0.
- R4: Reading a codeword with any nonzero error pattern in exactly one nibble, check nibbles included, returns the original data with `rd_fixed` = 1 and `rd_bad` = 0.
- R5: Reading a codeword with nonzero error patterns in exactly two nibbles gives `rd_bad` = 1 and `rd_fixed` = 0. `rd_data` then equals the received data field, unmodified.
- R6: `rd_fixed` and `rd_bad` are never 1 together, and neither is 1 unless `rd_out_valid` is 1.
- R7: `rd_out_valid` is 1 exactly one cycle after `rd_valid` was 1, and 0 otherwise.
- R8: Reads presented on consecutive cycles each produce their own independent result on consecutive cycles.
- R9: In a cycle after one with `rd_valid` = 0, `rd_data` keeps its previous value whatever `rd_code` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Write data strobe |
| wr_data | input | 48 | Data word to encode |
| wr_out_valid | output | 1 | Codeword valid, one cycle after `wr_valid` |
| wr_code | output | 60 | Codeword: check nibbles low, data nibbles high |
| rd_valid | input | 1 | Read codeword strobe |
| rd_code | input | 60 | Codeword as read from memory |
| rd_out_valid | output | 1 | Read result valid, one cycle after `rd_valid` |
| rd_data | output | 48 | Corrected (or passed-through) data |
| rd_fixed | output | 1 | A single-nibble error was corrected |
| rd_bad | output | 1 | Uncorrectable error detected |

## Verification
The hardest situations to reach are double-nibble errors whose first syndrome is zero while the others are not, and errors that land in the check nibbles. Random data alone would almost never produce these. The stimulus builds on codewords that the design's own write port produced. It then sweeps all 15 nonzero patterns through every one of the 15 nibble positions, streamed back to back. After that it applies a few hundred random pairs of distinct positions, each with nonzero patterns. Equal patterns in two nibbles give S0 = 0, and the random pairs hit that corner many times.

// File: rtl/nsc_gf_pkg.sv
package nsc_gf_pkg;

  localparam int SYM_W  = 4;
  localparam int CHK_SYMS = 3;
  localparam int FIELD_N = 15;

  // Generator (x+1)(x+a)(x+a^2) = x^3 + 7x^2 + 14x + 8 over GF(16)
  localparam logic [3:0] GEN2 = 4'd7;
  localparam logic [3:0] GEN1 = 4'd14;
  localparam logic [3:0] GEN0 = 4'd8;

  function automatic logic [3:0] gf_mul(input logic [3:0] x, input logic [3:0] y);
    logic [3:0] acc;
    logic [3:0] sh;
    acc = '0;
    sh  = x;
    for (int b = 0; b < 4; b++) begin
      if (y[b]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'b0011 : 4'b0000);
    end
    return acc;
  endfunction

  function automatic logic [3:0] gf_apow(input int k);
    logic [3:0] v;
    v = 4'd1;
    for (int t = 0; t < (k % FIELD_N); t++) v = gf_mul(v, 4'd2);
    return v;
  endfunction

endpackage

// File: rtl/nsc_encoder.sv
module nsc_encoder
  import nsc_gf_pkg::*;
#(
  parameter int DATA_SYMS = 12,
  localparam int DW = DATA_SYMS * SYM_W,
  localparam int KW = CHK_SYMS * SYM_W
) (
  input  logic [DW-1:0] data,
  output logic [KW-1:0] chk
);

  logic [3:0] rem0, rem1, rem2, fb;

  // Remainder of d(x)*x^3 divided by the generator, highest symbol first
  always_comb begin
    rem0 = '0;
    rem1 = '0;
    rem2 = '0;
    fb   = '0;
    for (int k = DATA_SYMS - 1; k >= 0; k--) begin
      fb   = data[k*SYM_W +: SYM_W] ^ rem2;
      rem2 = rem1 ^ gf_mul(fb, GEN2);
      rem1 = rem0 ^ gf_mul(fb, GEN1);
      rem0 = gf_mul(fb, GEN0);
    end
    chk = {rem2, rem1, rem0};
  end

endmodule

// File: rtl/nsc_syndrome.sv
module nsc_syndrome
  import nsc_gf_pkg::*;
#(
  parameter int NSYM = 15,
  localparam int CW = NSYM * SYM_W
) (
  input  logic [CW-1:0] code,
  output logic [3:0]    s0,
  output logic [3:0]    s1,
  output logic [3:0]    s2
);

  logic [3:0] t1 [NSYM];
  logic [3:0] t2 [NSYM];

  for (genvar i = 0; i < NSYM; i++) begin : g_term
    localparam logic [3:0] W1 = gf_apow(i);
    localparam logic [3:0] W2 = gf_apow(2 * i);
    assign t1[i] = gf_mul(code[i*SYM_W +: SYM_W], W1);
    assign t2[i] = gf_mul(code[i*SYM_W +: SYM_W], W2);
  end

  always_comb begin
    s0 = '0;
    s1 = '0;
    s2 = '0;
    for (int i = 0; i < NSYM; i++) begin
      s0 = s0 ^ code[i*SYM_W +: SYM_W];
      s1 = s1 ^ t1[i];
      s2 = s2 ^ t2[i];
    end
  end

endmodule

// File: rtl/nsc_locator.sv
module nsc_locator
  import nsc_gf_pkg::*;
#(
  parameter int NSYM = 15
) (
  input  logic [3:0]      s0,
  input  logic [3:0]      s1,
  input  logic [3:0]      s2,
  output logic [NSYM-1:0] hit,
  output logic            fixed,
  output logic            bad
);

  logic any_err;
  logic consistent;

  // One symbol error e at p: S0=e, S1=e*a^p, S2=e*a^2p, so S1^2 == S0*S2
  assign any_err    = (s0 != '0) || (s1 != '0) || (s2 != '0);
  assign consistent = (s0 != '0) && (s1 != '0) && (s2 != '0) &&
                      (gf_mul(s1, s1) == gf_mul(s0, s2));

  for (genvar i = 0; i < NSYM; i++) begin : g_pos
    localparam logic [3:0] AP = gf_apow(i);
    assign hit[i] = consistent && (gf_mul(s0, AP) == s1);
  end

  // A ratio pointing past the stored symbols leaves hit empty
  assign fixed = |hit;
  assign bad   = any_err && !fixed;

endmodule

// File: rtl/nibble_ecc.sv
module nibble_ecc
  import nsc_gf_pkg::*;
#(
  parameter int DATA_SYMS = 12,
  localparam int NSYM = DATA_SYMS + CHK_SYMS,
  localparam int DW   = DATA_SYMS * SYM_W,
  localparam int KW   = CHK_SYMS * SYM_W,
  localparam int CW   = NSYM * SYM_W
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_out_valid,
  output logic [CW-1:0] wr_code,
  input  logic          rd_valid,
  input  logic [CW-1:0] rd_code,
  output logic          rd_out_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_fixed,
  output logic          rd_bad
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  // Write path
  logic [KW-1:0] enc_chk;

  nsc_encoder #(.DATA_SYMS(DATA_SYMS)) u_enc (
    .data (wr_data),
    .chk  (enc_chk)
  );

  // Read path
  logic [3:0]      syn0, syn1, syn2;
  logic [NSYM-1:0] err_hit;
  logic            loc_fixed, loc_bad;
  logic [CW-1:0]   fix_code;

  nsc_syndrome #(.NSYM(NSYM)) u_syn (
    .code (rd_code),
    .s0   (syn0),
    .s1   (syn1),
    .s2   (syn2)
  );

  nsc_locator #(.NSYM(NSYM)) u_loc (
    .s0    (syn0),
    .s1    (syn1),
    .s2    (syn2),
    .hit   (err_hit),
    .fixed (loc_fixed),
    .bad   (loc_bad)
  );

  for (genvar i = 0; i < NSYM; i++) begin : g_fix
    assign fix_code[i*SYM_W +: SYM_W] =
      rd_code[i*SYM_W +: SYM_W] ^ (err_hit[i] ? syn0 : 4'h0);
  end

  // Next-state logic
  logic          wr_v_d, rd_v_d, fixed_d, bad_d;
  logic [CW-1:0] wr_code_d;
  logic [DW-1:0] rd_data_d;

  always_comb begin
    wr_v_d    = wr_valid;
    wr_code_d = wr_valid ? {wr_data, enc_chk} : wr_code;
    rd_v_d    = rd_valid;
    rd_data_d = rd_valid ? fix_code[CW-1:KW] : rd_data;
    fixed_d   = rd_valid && loc_fixed;
    bad_d     = rd_valid && loc_bad;
  end

  // Registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wr_out_valid <= 1'b0;
      wr_code      <= '0;
      rd_out_valid <= 1'b0;
      rd_data      <= '0;
      rd_fixed     <= 1'b0;
      rd_bad       <= 1'b0;
    end else if (!rst_ok) begin
      wr_out_valid <= 1'b0;
      wr_code      <= '0;
      rd_out_valid <= 1'b0;
      rd_data      <= '0;
      rd_fixed     <= 1'b0;
      rd_bad       <= 1'b0;
    end else begin
      wr_out_valid <= wr_v_d;
      wr_code      <= wr_code_d;
      rd_out_valid <= rd_v_d;
      rd_data      <= rd_data_d;
      rd_fixed     <= fixed_d;
      rd_bad       <= bad_d;
    end
  end

endmodule

// File: rtl/nsc_checker.sv
module nsc_checker #(
  parameter int DW = 48,
  parameter int CW = 60
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          wr_valid,
  input logic [DW-1:0] wr_data,
  input logic          wr_out_valid,
  input logic [CW-1:0] wr_code,
  input logic          rd_valid,
  input logic [CW-1:0] rd_code,
  input logic          rd_out_valid,
  input logic [DW-1:0] rd_data,
  input logic          rd_fixed,
  input logic          rd_bad
);

  localparam int KW = CW - DW;

  // R1: nothing valid while held in reset
  always_comb begin
    if (!rst_ok) begin
      a_reset_quiet_r1: assert (!wr_out_valid && !rd_out_valid && !rd_fixed && !rd_bad);
    end
  end

  p_wr_lat_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_valid |=> wr_out_valid && (wr_code[CW-1:KW] == $past(wr_data)));

  p_clean_pass_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_out_valid && !rd_fixed) |-> (rd_data == $past(rd_code[CW-1:KW])));

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    !(rd_fixed && rd_bad));

  p_flags_valid_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_fixed || rd_bad) |-> rd_out_valid);

  p_rd_lat_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_valid |=> rd_out_valid);

  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_valid |=> !rd_out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_valid |=> $stable(rd_data));

endmodule

bind nibble_ecc nsc_checker #(.DW(DW), .CW(CW)) u_nsc_checker (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .wr_valid     (wr_valid),
  .wr_data      (wr_data),
  .wr_out_valid (wr_out_valid),
  .wr_code      (wr_code),
  .rd_valid     (rd_valid),
  .rd_code      (rd_code),
  .rd_out_valid (rd_out_valid),
  .rd_data      (rd_data),
  .rd_fixed     (rd_fixed),
  .rd_bad       (rd_bad)
);

// File: tb/nibble_ecc_test.sv
module nibble_ecc_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 48;
  localparam int CW = 60;
  localparam int NWORDS = 5;

  logic          clk;
  logic          arst_n;
  logic          wr_valid;
  logic [DW-1:0] wr_data;
  logic          wr_out_valid;
  logic [CW-1:0] wr_code;
  logic          rd_valid;
  logic [CW-1:0] rd_code;
  logic          rd_out_valid;
  logic [DW-1:0] rd_data;
  logic          rd_fixed;
  logic          rd_bad;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  nibble_ecc uut (
    .clk          (clk),
    .arst_n       (arst_n),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .wr_out_valid (wr_out_valid),
    .wr_code      (wr_code),
    .rd_valid     (rd_valid),
    .rd_code      (rd_code),
    .rd_out_valid (rd_out_valid),
    .rd_data      (rd_data),
    .rd_fixed     (rd_fixed),
    .rd_bad       (rd_bad)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Bench-side GF(16) arithmetic, modulus x^4+x+1
  function automatic logic [3:0] bm(input logic [3:0] x, input logic [3:0] y);
    logic [3:0] r;
    logic [3:0] s;
    r = 0;
    s = x;
    for (int b = 0; b < 4; b++) begin
      if (y[b]) r ^= s;
      s = s[3] ? ({s[2:0], 1'b0} ^ 4'h3) : {s[2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [3:0] bsyn(input logic [CW-1:0] c, input int j);
    logic [3:0] acc;
    logic [3:0] w;
    acc = 0;
    for (int i = 0; i < 15; i++) begin
      w = 4'd1;
      for (int t = 0; t < j * i; t++) w = bm(w, 4'd2);
      acc ^= bm(c[i*4 +: 4], w);
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard
  logic [DW-1:0] q_data [$];
  logic          q_fix  [$];
  logic          q_bad  [$];
  string         q_req  [$];

  task automatic send_read(input logic [CW-1:0] c, input logic [DW-1:0] ed,
                           input logic ef, input logic eb, input string req);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_code  = c;
    q_data.push_back(ed);
    q_fix.push_back(ef);
    q_bad.push_back(eb);
    q_req.push_back(req);
  endtask

  task automatic idle_read();
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  bit mon_on = 0;
  always @(negedge clk) begin
    if (mon_on && rd_out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R7", "unexpected rd_out_valid", 64'd1, 64'd0);
      end else begin
        logic [DW-1:0] ed;
        logic ef, eb;
        string rq;
        ed = q_data.pop_front();
        ef = q_fix.pop_front();
        eb = q_bad.pop_front();
        rq = q_req.pop_front();
        check((rd_data == ed) && (rd_fixed == ef) && (rd_bad == eb), rq,
              "data/fixed/bad", {rd_fixed, rd_bad, 14'd0, rd_data},
              {ef, eb, 14'd0, ed});
        // R6: flags exclusive
        check(!(rd_fixed && rd_bad), "R6", "both flags", {62'd0, rd_fixed, rd_bad}, 64'd0);
      end
    end
  end

  logic [CW-1:0] codes [NWORDS];
  logic [DW-1:0] words [NWORDS];

  task automatic do_write(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = ~d;
    // R2: codeword one cycle later, data field and zero syndromes
    check(wr_out_valid == 1'b1, "R2", "wr_out_valid", {63'd0, wr_out_valid}, 64'd1);
    check(wr_code[CW-1:12] == d, "R2", "data field", {16'd0, wr_code[CW-1:12]}, {16'd0, d});
    for (int j = 0; j < 3; j++)
      check(bsyn(wr_code, j) == 4'h0, "R2", "syndrome", {60'd0, bsyn(wr_code, j)}, 64'd0);
    codes[idx] = wr_code;
    words[idx] = d;
  endtask

  initial begin
    arst_n   = 1'b0;
    wr_valid = 1'b0;
    wr_data  = '0;
    rd_valid = 1'b0;
    rd_code  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!wr_out_valid && !rd_out_valid && !rd_fixed && !rd_bad, "R1", "reset outputs",
          {60'd0, wr_out_valid, rd_out_valid, rd_fixed, rd_bad}, 64'd0);
    arst_n = 1'b1;
    @(negedge clk);
    check(!wr_out_valid && !rd_out_valid, "R1", "outputs during release",
          {62'd0, wr_out_valid, rd_out_valid}, 64'd0);
    repeat (3) @(negedge clk);
    mon_on = 1;

    do_write(0, 48'h0);
    do_write(1, {48{1'b1}});
    do_write(2, 48'h0123_4567_89AB);
    do_write(3, 48'hA5A5_5A5A_F00F);
    do_write(4, {$urandom(), $urandom()} & {48{1'b1}});

    // R3: clean reads, R8: back to back
    for (int w = 0; w < NWORDS; w++) send_read(codes[w], words[w], 1'b0, 1'b0, "R3");

    // R4: every nonzero pattern in every nibble, streamed (R8)
    for (int w = 0; w < NWORDS; w++)
      for (int p = 0; p < 15; p++)
        for (int e = 1; e < 16; e++) begin
          logic [CW-1:0] c;
          c = codes[w];
          c[p*4 +: 4] ^= 4'(e);
          send_read(c, words[w], 1'b1, 1'b0, "R4");
        end
    idle_read();

    // R9 / R7: gap cycles with changing rd_code must not disturb rd_data
    @(negedge clk);
    begin
      logic [DW-1:0] held;
      held = rd_data;
      rd_code = ~codes[2];
      @(negedge clk);
      check(rd_data == held, "R9", "rd_data held", {16'd0, rd_data}, {16'd0, held});
      check(!rd_out_valid, "R7", "rd_out_valid idle", {63'd0, rd_out_valid}, 64'd0);
    end

    // R5: two corrupted nibbles, data passes through unmodified
    for (int n = 0; n < 300; n++) begin
      logic [CW-1:0] c;
      int w, p1, p2;
      logic [3:0] e1, e2;
      w  = n % NWORDS;
      p1 = $urandom_range(14, 0);
      p2 = (p1 + 1 + $urandom_range(13, 0)) % 15;
      e1 = 4'($urandom_range(15, 1));
      e2 = (n % 4 == 0) ? e1 : 4'($urandom_range(15, 1));
      c = codes[w];
      c[p1*4 +: 4] ^= e1;
      c[p2*4 +: 4] ^= e2;
      send_read(c, c[CW-1:12], 1'b0, 1'b1, "R5");
    end
    idle_read();
    repeat (3) @(negedge clk);
    check(q_data.size() == 0, "R8", "results outstanding", 64'(q_data.size()), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule